// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This combinational block resolves one relative branch per evaluation. It takes the opcode byte of the instruction being executed, the current condition code byte, the sampled level of the external interrupt request pin, the signed relative displacement that follows the opcode and the address of the next sequential instruction. It reports whether the branch is taken and the program counter to fetch from next.

Two opcode groups are recognised. The `$2x` group covers the unconditional pair, the unsigned-magnitude tests, the single-flag tests on carry, zero, half carry, negative and the interrupt mask, and the tests on the interrupt pin. The `$90`–`$93` group covers the signed-magnitude tests. Within each group, an even opcode is the complement of the odd opcode that follows it. A taken branch adds the sign-extended displacement to the next-instruction address, with the sum wrapping modulo the counter width. Any other outcome returns the next-instruction address unchanged.

Top module: `branch_decide`

## Requirements
- R1: The condition byte is read with V at bit 7, H at bit 4, I at bit 3, N at bit 2, Z at bit 1 and C at bit 0. Opcode 0x20 is always taken and 0x21 is never taken.
- R2: Opcode 0x22 is taken when C and Z are both 0. Opcode 0x23 is taken when C or Z is 1.
- R3: Opcodes 0x24 and 0x25 are taken when C is 0 and when C is 1. Opcodes 0x26 and 0x27 are taken when Z is 0 and when Z is 1.
- R4: Opcodes 0x28 and 0x29 are taken when H is 0 and when H is 1. Opcodes 0x2A and 0x2B are taken when N is 0 and when N is 1.
- R5: Opcode 0x2C is taken when I is 0, and 0x2D is taken when I is 1.
- R6: Opcode 0x2E is taken when the interrupt pin is low, and 0x2F is taken when it is high. The pin affects no other opcode.
- R7: Opcode 0x90 is taken when N xor V is 0, and 0x91 when N xor V is 1.
- R8: Opcode 0x92 is taken when Z or (N xor V) is 0, and 0x93 when it is 1.
- R9: When the branch is taken, the PC output equals the next-instruction address plus the sign-extended displacement, modulo 2^PC_W.
- R10: When the branch is not taken, the PC output equals the next-instruction address.
- R11: Every opcode outside 0x20–0x2F and 0x90–0x93 gives taken = 0, whatever the flags, pin and displacement.
- R12: Bits 6 and 5 of the condition byte have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 8 | Opcode byte of the current instruction |
| ccr_in | input | 8 | Condition code byte |
| irq_level | input | 1 | Sampled level of the interrupt request pin |
| rel_ofs | input | OFS_W | Signed relative displacement |
| pc_next | input | PC_W | Address of the next sequential instruction |
| take | output | 1 | High when the branch is taken |
| pc_out | output | PC_W | Program counter to fetch from next |

## Verification
Immediate assertions run on every evaluation and cover several invariants: that a taken result moves the PC by exactly the sign-extended displacement, that a result which is not taken leaves the PC alone, that no opcode outside the two groups is taken, that the unconditional pair is fixed, and that the pin pair follows the pin. Only the bench scenarios can show that each flag condition selects the correct bit and polarity. To do that they sweep every condition byte and both pin levels for each branch opcode, and run wrap-around and negative displacements and all non-branch opcodes.

// File: rtl/bdu_pkg.sv
package bdu_pkg;

   // condition code bit positions (behavioural: the condition byte is decoded by them)
   localparam int CCR_V = 7;
   localparam int CCR_H = 4;
   localparam int CCR_I = 3;
   localparam int CCR_N = 2;
   localparam int CCR_Z = 1;
   localparam int CCR_C = 0;

   // upper nibbles of the two branch groups
   localparam logic [3:0] GRP_FLAG   = 4'h2;
   localparam logic [3:0] GRP_SIGNED = 4'h9;

   // condition selector taken from opcode bits [3:1] in the flag group
   typedef enum logic [2:0] {
      SEL_FALSE = 3'd0,
      SEL_CZ    = 3'd1,
      SEL_C     = 3'd2,
      SEL_Z     = 3'd3,
      SEL_H     = 3'd4,
      SEL_N     = 3'd5,
      SEL_I     = 3'd6,
      SEL_PIN   = 3'd7
   } cond_sel_e;

   typedef struct packed {
      logic v;
      logic h;
      logic i;
      logic n;
      logic z;
      logic c;
   } flags_t;

   function automatic flags_t split_ccr(input logic [7:0] r);
      flags_t f;
      f.v = r[CCR_V];
      f.h = r[CCR_H];
      f.i = r[CCR_I];
      f.n = r[CCR_N];
      f.z = r[CCR_Z];
      f.c = r[CCR_C];
      return f;
   endfunction

endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
   import bdu_pkg::*;
#(
   parameter bit SIGNED_GRP_EN = 1'b1
) (
   input  logic [7:0] op_code,
   input  flags_t     flags,
   input  logic       irq_level,
   output logic       is_branch,
   output logic       hit
);

   logic      flag_grp;
   logic      sgn_grp;
   logic      raw_flag;
   logic      raw_sgn;
   cond_sel_e sel;

   assign flag_grp = (op_code[7:4] == GRP_FLAG);
   assign sel      = cond_sel_e'(op_code[3:1]);

   // raw condition for the flag group; the odd opcode takes on raw, the even one on its inverse
   always_comb begin
      unique case (sel)
         SEL_FALSE: raw_flag = 1'b0;
         SEL_CZ:    raw_flag = flags.c | flags.z;
         SEL_C:     raw_flag = flags.c;
         SEL_Z:     raw_flag = flags.z;
         SEL_H:     raw_flag = flags.h;
         SEL_N:     raw_flag = flags.n;
         SEL_I:     raw_flag = flags.i;
         SEL_PIN:   raw_flag = irq_level;
         default:   raw_flag = 1'b0;
      endcase
   end

   generate
      if (SIGNED_GRP_EN) begin : g_signed
         assign sgn_grp = (op_code[7:4] == GRP_SIGNED) && (op_code[3:2] == 2'b00);
         assign raw_sgn = op_code[1] ? (flags.z | (flags.n ^ flags.v)) : (flags.n ^ flags.v);
      end else begin : g_nosigned
         assign sgn_grp = 1'b0;
         assign raw_sgn = 1'b0;
      end
   endgenerate

   assign is_branch = flag_grp | sgn_grp;
   assign hit = is_branch & (op_code[0] ? (flag_grp ? raw_flag : raw_sgn)
                                        : ~(flag_grp ? raw_flag : raw_sgn));

   always_comb begin
      assert_nonbranch_R11: assert (is_branch || !hit)
         else $error("non-branch opcode %h reported taken", op_code);
      if (op_code == 8'h20) begin
         assert_always_R1: assert (hit) else $error("0x20 not taken");
      end
      if (op_code == 8'h21) begin
         assert_never_R1: assert (!hit) else $error("0x21 taken");
      end
      if (op_code[7:1] == 7'h17) begin
         assert_pin_R6: assert (hit == (irq_level == op_code[0]))
            else $error("pin branch %h mismatched pin %b", op_code, irq_level);
      end
   end

endmodule

// File: rtl/branch_target_add.sv
module branch_target_add #(
   parameter int PC_W  = 16,
   parameter int OFS_W = 8
) (
   input  logic [PC_W-1:0]  pc_base,
   input  logic [OFS_W-1:0] rel_ofs,
   output logic [PC_W-1:0]  target
);

   localparam int EXT_W = PC_W - OFS_W;

   logic [PC_W-1:0] ofs_ext;

   generate
      if (EXT_W > 0) begin : g_extend
         assign ofs_ext = {{EXT_W{rel_ofs[OFS_W-1]}}, rel_ofs};
      end else begin : g_equal
         assign ofs_ext = rel_ofs[PC_W-1:0];
      end
   endgenerate

   assign target = pc_base + ofs_ext;

endmodule

// File: rtl/branch_decide.sv
module branch_decide
   import bdu_pkg::*;
#(
   parameter int PC_W          = 16,
   parameter int OFS_W         = 8,
   parameter bit SIGNED_GRP_EN = 1'b1
) (
   input  logic [7:0]       op_code,
   input  logic [7:0]       ccr_in,
   input  logic             irq_level,
   input  logic [OFS_W-1:0] rel_ofs,
   input  logic [PC_W-1:0]  pc_next,
   output logic             take,
   output logic [PC_W-1:0]  pc_out
);

   generate
      if (OFS_W < 2 || OFS_W > PC_W) begin : g_bad_ofs
         $error("OFS_W must lie in 2..PC_W");
      end
      if (PC_W < 2 || PC_W > 64) begin : g_bad_pc
         $error("PC_W must lie in 2..64");
      end
   endgenerate

   flags_t          flags;
   logic            is_branch;
   logic            hit;
   logic [PC_W-1:0] target;
   logic [PC_W-1:0] ofs_ref;

   assign flags = split_ccr(ccr_in);

   branch_cond_eval #(.SIGNED_GRP_EN(SIGNED_GRP_EN)) u_cond (
      .op_code   (op_code),
      .flags     (flags),
      .irq_level (irq_level),
      .is_branch (is_branch),
      .hit       (hit)
   );

   branch_target_add #(.PC_W(PC_W), .OFS_W(OFS_W)) u_add (
      .pc_base (pc_next),
      .rel_ofs (rel_ofs),
      .target  (target)
   );

   assign take   = hit;
   assign pc_out = hit ? target : pc_next;

   // displacement recovered from the outputs, compared with the sign-extended input
   assign ofs_ref = PC_W'($signed(rel_ofs));

   always_comb begin
      if (take) begin
         assert_target_R9: assert (PC_W'(pc_out - pc_next) == ofs_ref)
            else $error("taken pc %h from %h ofs %h", pc_out, pc_next, rel_ofs);
      end else begin
         assert_hold_R10: assert (pc_out == pc_next)
            else $error("not-taken pc moved %h -> %h", pc_next, pc_out);
      end
   end

endmodule

// File: tb/branch_decide_bench.sv
module branch_decide_bench;

   localparam int PC_W  = 16;
   localparam int OFS_W = 8;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [7:0]       op_code = 8'h00;
   logic [7:0]       ccr_in = 8'h00;
   logic             irq_level = 1'b0;
   logic [OFS_W-1:0] rel_ofs = '0;
   logic [PC_W-1:0]  pc_next = '0;
   logic             take;
   logic [PC_W-1:0]  pc_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   branch_decide #(.PC_W(PC_W), .OFS_W(OFS_W)) u_branch_decide (
      .op_code   (op_code),
      .ccr_in    (ccr_in),
      .irq_level (irq_level),
      .rel_ofs   (rel_ofs),
      .pc_next   (pc_next),
      .take      (take),
      .pc_out    (pc_out)
   );

   // expected taken flag, written per opcode straight from the requirements
   function automatic bit ref_take(input logic [7:0] op, input logic [7:0] r, input logic pin);
      bit v, h, i, n, z, c;
      v = r[7]; h = r[4]; i = r[3]; n = r[2]; z = r[1]; c = r[0];
      case (op)
         8'h20: return 1'b1;
         8'h21: return 1'b0;
         8'h22: return (c == 0) && (z == 0);
         8'h23: return (c == 1) || (z == 1);
         8'h24: return c == 0;
         8'h25: return c == 1;
         8'h26: return z == 0;
         8'h27: return z == 1;
         8'h28: return h == 0;
         8'h29: return h == 1;
         8'h2A: return n == 0;
         8'h2B: return n == 1;
         8'h2C: return i == 0;
         8'h2D: return i == 1;
         8'h2E: return pin == 0;
         8'h2F: return pin == 1;
         8'h90: return (n != v) == 0;
         8'h91: return (n != v) == 1;
         8'h92: return (z || (n != v)) == 0;
         8'h93: return (z || (n != v)) == 1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string req_of(input logic [7:0] op);
      case (op)
         8'h20, 8'h21: return "R1";
         8'h22, 8'h23: return "R2";
         8'h24, 8'h25, 8'h26, 8'h27: return "R3";
         8'h28, 8'h29, 8'h2A, 8'h2B: return "R4";
         8'h2C, 8'h2D: return "R5";
         8'h2E, 8'h2F: return "R6";
         8'h90, 8'h91: return "R7";
         8'h92, 8'h93: return "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic apply_check(input logic [7:0] op, input logic [7:0] r, input logic pin,
                              input logic [OFS_W-1:0] ofs, input logic [PC_W-1:0] pc,
                              input string tag);
      bit              exp_t;
      logic [PC_W-1:0] exp_pc;
      @(negedge clk);
      op_code = op; ccr_in = r; irq_level = pin; rel_ofs = ofs; pc_next = pc;
      #2;
      exp_t  = ref_take(op, r, pin);
      exp_pc = exp_t ? PC_W'(int'(pc) + int'($signed(ofs))) : pc;
      checks++;
      if (take !== exp_t) begin
         errors++;
         $display("FAIL %s op=%h ccr=%h pin=%b take actual=%b expected=%b",
                  tag, op, r, pin, take, exp_t);
      end
      checks++;
      if (pc_out !== exp_pc) begin
         errors++;
         $display("FAIL %s op=%h ccr=%h pc actual=%h expected=%h", tag, op, r, pc_out, exp_pc);
      end
   endtask

   // sweep every condition byte and both pin levels for one opcode
   task automatic sweep_op(input logic [7:0] op);
      for (int r = 0; r < 256; r++) begin
         for (int p = 0; p < 2; p++) begin
            apply_check(op, 8'(r), 1'(p), 8'h05, 16'h1234, req_of(op));
         end
      end
   endtask

   task automatic t_idle_state;   // reset-time inputs: no branch, PC passes
      apply_check(8'h00, 8'h00, 1'b0, 8'h00, 16'h0000, "R11");
   endtask

   task automatic t_fixed;        // R1
      sweep_op(8'h20);
      sweep_op(8'h21);
   endtask

   task automatic t_unsigned;     // R2
      sweep_op(8'h22);
      sweep_op(8'h23);
   endtask

   task automatic t_carry_zero;   // R3
      for (int o = 8'h24; o <= 8'h27; o++) sweep_op(8'(o));
   endtask

   task automatic t_half_neg;     // R4
      for (int o = 8'h28; o <= 8'h2B; o++) sweep_op(8'(o));
   endtask

   task automatic t_mask;         // R5
      sweep_op(8'h2C);
      sweep_op(8'h2D);
   endtask

   task automatic t_pin;          // R6
      sweep_op(8'h2E);
      sweep_op(8'h2F);
   endtask

   task automatic t_signed;       // R7, R8
      for (int o = 8'h90; o <= 8'h93; o++) sweep_op(8'(o));
   endtask

   task automatic t_target;       // R9, R10
      apply_check(8'h20, 8'h00, 1'b0, 8'h7F, 16'h1000, "R9");
      apply_check(8'h20, 8'h00, 1'b0, 8'h80, 16'h1000, "R9");
      apply_check(8'h20, 8'h00, 1'b0, 8'hFF, 16'h0000, "R9");
      apply_check(8'h20, 8'h00, 1'b0, 8'h10, 16'hFFF8, "R9");
      apply_check(8'h27, 8'h02, 1'b0, 8'hFE, 16'h4001, "R9");
      apply_check(8'h27, 8'h00, 1'b0, 8'hFE, 16'h4001, "R10");
      apply_check(8'h21, 8'hFF, 1'b1, 8'h40, 16'hABCD, "R10");
   endtask

   task automatic t_nonbranch;    // R11
      for (int o = 0; o < 256; o++) begin
         if (!((o >= 8'h20 && o <= 8'h2F) || (o >= 8'h90 && o <= 8'h93))) begin
            apply_check(8'(o), 8'hFF, 1'b1, 8'h33, 16'h2222, "R11");
            apply_check(8'(o), 8'h00, 1'b0, 8'hC0, 16'h0100, "R11");
         end
      end
   endtask

   task automatic t_unused_bits;  // R12: toggling bits 6 and 5 changes nothing
      for (int o = 8'h20; o <= 8'h2F; o++) begin
         apply_check(8'(o), 8'h60, 1'b0, 8'h09, 16'h3000, "R12");
         apply_check(8'(o), 8'h00, 1'b0, 8'h09, 16'h3000, "R12");
      end
      for (int o = 8'h90; o <= 8'h93; o++) begin
         apply_check(8'(o), 8'h60, 1'b1, 8'h09, 16'h3000, "R12");
         apply_check(8'(o), 8'h20, 1'b1, 8'h09, 16'h3000, "R12");
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle_state();
      t_fixed();
      t_unsigned();
      t_carry_zero();
      t_half_neg();
      t_mask();
      t_pin();
      t_signed();
      t_target();
      t_nonbranch();
      t_unused_bits();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule